// File: doc/BRIEF.md
# Comparator change-detect interrupt logic

This block sits between two analog comparators and a processor core. It watches the two digital comparator outputs. It raises a change flag when either output differs from a snapshot of the outputs. Software refreshes the snapshot each time it reads or writes the control/status register. Until that access happens, the difference keeps setting the flag. Software therefore acknowledges a change in two steps: it accesses the control/status register to end the mismatch, then writes 0 to the flag.

The block has two byte-wide registers, selected by one select bit. The control/status register holds a three-bit mode field and reports the two comparator outputs. The flag register holds the change flag. Three enable inputs gate the interrupt request: a local enable, a peripheral enable and a global enable. A separate wake request lets a sleeping core resume on a flagged change. The raw comparator outputs pass through a two-flop synchronizer before the block compares them. Two mode codes force the reported outputs low: the comparators-held-in-reset code and the comparators-off code.

Top module: `cmp_chg_irq`

## Requirements
- R1: When either synchronized, mode-gated comparator output differs from the snapshot, the flag is set. A raw input change that is stable before clock edge N shows as flag = 1 after edge N+2.
- R2: The mismatch sets the flag again on every cycle until software reads or writes the control/status register (select = 0). That access loads the snapshot with the current outputs, which ends the mismatch.
- R3: In the flag register (select = 1), the flag is bit 0. Writing 0 there clears the flag and writing 1 sets it. When a mismatch and a write of 0 fall in the same cycle, the mismatch wins and the flag stays set.
- R4: irq_o is 1 only while the flag, local_en_i, periph_en_i and global_en_i are all 1. The flag sets whatever the enables are.
- R5: Suppose an output change reaches the compare in the same cycle as a control/status access. The flag is not set for that change, and the snapshot takes the new value.
- R6: After reset, the mode field is 000, the flag is 0 and the snapshot is 0. While the mode is 000, the reported comparator outputs are 0.
- R7: While the mode is 111, both reported comparator outputs are 0.
- R8: The control/status register reads as follows: bit 7 = comparator 1, bit 6 = comparator 0, bits 2:0 = mode, and every other bit 0. A write sets only the mode bits, so writes to bits 7:6 are ignored. The flag register reads the flag in bit 0 and 0 in bits 7:1. Read data follows the current select input combinationally.
- R9: wake_o equals sleep_i AND flag AND local_en_i AND periph_en_i. The global enable is not needed. Sleeping changes no register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw_i | input | 2 | Raw comparator outputs (bit 1 = comparator 1) |
| reg_sel_i | input | 1 | Register select: 0 control/status, 1 flag |
| reg_rd_i | input | 1 | Read strobe for the selected register |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| local_en_i | input | 1 | Local interrupt enable |
| periph_en_i | input | 1 | Peripheral interrupt enable |
| global_en_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Core is sleeping |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to a sleeping core |
| mode_o | output | 3 | Current mode field, sent to the analog side |

## Verification
The hardest case to reach is the lost change of R5. An output change has to arrive at the compare in exactly the cycle that a control/status access is sampled. The raw input passes two synchronizer flops first, so the stimulus changes the raw input, waits two idle edges, and then issues the read for the third edge. A control run without the read then shows that the same change does set the flag. A long pseudo-random phase also issues sparse register accesses against a toggling comparator input. It hits this race and the R3 priority collision many more times, and a behavioural model compares every output on every clock.

// File: rtl/cmpirq_pkg.sv
// Package: shared constants and helpers for the comparator change-detect
// interrupt logic. Assumes a three-bit mode field in the low bits of the
// control/status register.
package cmpirq_pkg;

    localparam int MODE_W   = 3;
    localparam int FLAG_BIT = 0;

    typedef logic [MODE_W-1:0] mode_t;

    // Mode codes that force the reported comparator outputs low.
    localparam mode_t MODE_HOLD_RST = 3'b000;
    localparam mode_t MODE_ALL_OFF  = 3'b111;

    // Register select encoding.
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_FLAG = 1'b1;

    // True when the mode keeps the comparator outputs at zero.
    function automatic logic outputs_forced_low(input mode_t m);
        return (m == MODE_HOLD_RST) || (m == MODE_ALL_OFF);
    endfunction

endpackage

// File: rtl/cmpirq_sync.sv
// Module: multi-flop synchronizer for the raw comparator outputs.
// Assumes that each bit is an independent level and may be sampled one flop
// apart from the others. All flops clear on reset.
module cmpirq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;

            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= d_i;
            end

            assign q_o = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_q;

            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], d_i};
            end

            assign q_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cmpirq_ctrl.sv
// Module: mode register, output gating and snapshot compare.
// Assumes that sync_i is already synchronized. A read or write of the
// control/status register loads the snapshot and masks the mismatch in that
// same cycle, so a change arriving exactly then is absorbed.
module cmpirq_ctrl
    import cmpirq_pkg::*;
#(
    parameter int NCMP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCMP-1:0] sync_i,
    input  logic            ctrl_rd_i,
    input  logic            ctrl_wr_i,
    input  mode_t           mode_wdata_i,
    output mode_t           mode_o,
    output logic [NCMP-1:0] cmp_vis_o,
    output logic            mismatch_o
);

    mode_t           mode_q;
    logic [NCMP-1:0] snap_q;
    logic [NCMP-1:0] chg;
    logic            ctrl_access;
    logic            force_low;

    assign ctrl_access = ctrl_rd_i | ctrl_wr_i;
    assign force_low   = outputs_forced_low(mode_q);

    // Per-comparator output gating and change detection.
    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            assign cmp_vis_o[i] = sync_i[i] & ~force_low;
            assign chg[i]       = cmp_vis_o[i] ^ snap_q[i];
        end
    endgenerate

    // Mode field: a write of the control/status register updates it.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_HOLD_RST;
        else if (ctrl_wr_i) mode_q <= mode_wdata_i;
    end

    // Snapshot: any control/status access loads the visible outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)           snap_q <= '0;
        else if (ctrl_access) snap_q <= cmp_vis_o;
    end

    assign mismatch_o = (|chg) & ~ctrl_access;
    assign mode_o     = mode_q;

endmodule

// File: rtl/cmpirq_flag.sv
// Module: change flag with software set/clear, plus request gating.
// Assumes that mismatch_i is already masked for control/status accesses.
// A mismatch set outranks a software write in the same cycle.
module cmpirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch_i,
    input  logic flag_wr_i,
    input  logic flag_wbit_i,
    input  logic local_en_i,
    input  logic periph_en_i,
    input  logic global_en_i,
    input  logic sleep_i,
    output logic flag_o,
    output logic irq_o,
    output logic wake_o
);

    logic flag_q;
    logic src_en;

    // Flag register: hardware set first, then software write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (mismatch_i) flag_q <= 1'b1;
        else if (flag_wr_i)  flag_q <= flag_wbit_i;
    end

    assign src_en = flag_q & local_en_i & periph_en_i;
    assign irq_o  = src_en & global_en_i;
    assign wake_o = src_en & sleep_i;
    assign flag_o = flag_q;

endmodule

// File: rtl/cmp_chg_irq.sv
// Module: top of the comparator change-detect interrupt logic.
// Decodes two byte registers (select 0 control/status, select 1 flag) and
// wires the synchronizer, control and flag stages. Assumes that the
// comparator outputs plus the mode field fit in DW bits.
module cmp_chg_irq
    import cmpirq_pkg::*;
#(
    parameter int NCMP        = 2,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCMP-1:0]   cmp_raw_i,
    input  logic              reg_sel_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    input  logic              local_en_i,
    input  logic              periph_en_i,
    input  logic              global_en_i,
    input  logic              sleep_i,
    output logic              irq_o,
    output logic              wake_o,
    output logic [MODE_W-1:0] mode_o
);

    localparam int OUT_LSB = DW - NCMP;

    logic [NCMP-1:0] cmp_sync;
    logic [NCMP-1:0] cmp_vis;
    logic            mismatch;
    logic            flag_bit;
    logic            ctrl_rd;
    logic            ctrl_wr;
    logic            flag_wr;
    logic [DW-1:0]   ctrl_view;
    logic [DW-1:0]   flag_view;
    logic            unused_wdata_bits;

    assign ctrl_rd = reg_rd_i & (reg_sel_i == SEL_CTRL);
    assign ctrl_wr = reg_wr_i & (reg_sel_i == SEL_CTRL);
    assign flag_wr = reg_wr_i & (reg_sel_i == SEL_FLAG);

    assign unused_wdata_bits = ^reg_wdata_i;

    cmpirq_sync #(
        .WIDTH  (NCMP),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_raw_i),
        .q_o   (cmp_sync)
    );

    cmpirq_ctrl #(
        .NCMP (NCMP)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (cmp_sync),
        .ctrl_rd_i    (ctrl_rd),
        .ctrl_wr_i    (ctrl_wr),
        .mode_wdata_i (reg_wdata_i[MODE_W-1:0]),
        .mode_o       (mode_o),
        .cmp_vis_o    (cmp_vis),
        .mismatch_o   (mismatch)
    );

    cmpirq_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .mismatch_i  (mismatch),
        .flag_wr_i   (flag_wr),
        .flag_wbit_i (reg_wdata_i[FLAG_BIT]),
        .local_en_i  (local_en_i),
        .periph_en_i (periph_en_i),
        .global_en_i (global_en_i),
        .sleep_i     (sleep_i),
        .flag_o      (flag_bit),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    // Assemble the control/status read view: outputs on top, mode at bottom.
    always_comb begin
        ctrl_view                     = '0;
        ctrl_view[OUT_LSB +: NCMP]    = cmp_vis;
        ctrl_view[MODE_W-1:0]         = mode_o;
    end

    // Assemble the flag read view: flag alone at its bit.
    always_comb begin
        flag_view           = '0;
        flag_view[FLAG_BIT] = flag_bit;
    end

    // Read mux on the select input.
    always_comb begin
        reg_rdata_o = (reg_sel_i == SEL_FLAG) ? flag_view : ctrl_view;
    end

endmodule

// File: rtl/cmp_chg_irq_chk.sv
// Module: assertion checker for cmp_chg_irq, bound to every instance.
// Assumes the default 8-bit register layout with a 3-bit mode field.
module cmp_chg_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       local_en_i,
    input logic       periph_en_i,
    input logic       global_en_i,
    input logic       sleep_i,
    input logic       irq_o,
    input logic       wake_o,
    input logic [2:0] mode_o,
    input logic       flag_bit
);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (local_en_i && periph_en_i && global_en_i && flag_bit));

    // R9
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (sleep_i && local_en_i && periph_en_i && flag_bit));

    // R8
    ctrl_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == 1'b0) |-> (reg_rdata_o[5:3] == 3'b000));

    // R8
    flag_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == 1'b1) |-> (reg_rdata_o[7:1] == 7'd0));

    // R7
    forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_sel_i == 1'b0) && ((mode_o == 3'b111) || (mode_o == 3'b000)))
            |-> (reg_rdata_o[7:6] == 2'b00));

    // R6
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> ((mode_o == 3'b000) && !flag_bit));

    // R3
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_bit) && $past(rst_n))
            |-> $past(reg_wr_i && reg_sel_i && !reg_wdata_i[0]));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_o) && $past(rst_n)) |-> $past(reg_wr_i && !reg_sel_i));

endmodule

bind cmp_chg_irq cmp_chg_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel_i   (reg_sel_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .local_en_i  (local_en_i),
    .periph_en_i (periph_en_i),
    .global_en_i (global_en_i),
    .sleep_i     (sleep_i),
    .irq_o       (irq_o),
    .wake_o      (wake_o),
    .mode_o      (mode_o),
    .flag_bit    (flag_bit)
);

// File: tb/cmp_chg_irq_bench.sv
module cmp_chg_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = 2'b00;
    logic       reg_sel = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       local_en = 1'b0;
    logic       periph_en = 1'b0;
    logic       global_en = 1'b0;
    logic       sleep = 1'b0;
    logic       irq;
    logic       wake;
    logic [2:0] mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_chg_irq u_cmp_chg_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_raw_i   (cmp_raw),
        .reg_sel_i   (reg_sel),
        .reg_rd_i    (reg_rd),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .local_en_i  (local_en),
        .periph_en_i (periph_en),
        .global_en_i (global_en),
        .sleep_i     (sleep),
        .irq_o       (irq),
        .wake_o      (wake),
        .mode_o      (mode)
    );

    // Behavioural reference model: a delay queue for the synchronizer, plain state elsewhere.
    logic [1:0] m_pipe[$];
    logic [2:0] m_mode;
    logic [1:0] m_snap;
    logic       m_flag;

    function automatic logic [1:0] m_vis();
        if (m_mode == 3'd0 || m_mode == 3'd7) return 2'b00;
        return m_pipe[0];
    endfunction

    initial begin
        m_pipe = '{2'b00, 2'b00};
        m_mode = 3'd0;
        m_snap = 2'b00;
        m_flag = 1'b0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pipe = '{2'b00, 2'b00};
            m_mode = 3'd0;
            m_snap = 2'b00;
            m_flag = 1'b0;
        end else begin
            logic [1:0] vis;
            bit acc;
            vis = m_vis();
            acc = !reg_sel && (reg_rd || reg_wr);
            if (vis != m_snap && !acc) m_flag = 1'b1;
            else if (reg_sel && reg_wr) m_flag = reg_wdata[0];
            if (acc) m_snap = vis;
            if (!reg_sel && reg_wr) m_mode = reg_wdata[2:0];
            void'(m_pipe.pop_front());
            m_pipe.push_back(cmp_raw);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: wait for the edge, settle, compare every output with the model.
    task automatic cyc();
        logic [7:0] exp_rd;
        @(posedge clk);
        #2;
        exp_rd = reg_sel ? {7'd0, m_flag} : {m_vis(), 3'b000, m_mode};
        chk("R8 model rdata", reg_rdata, exp_rd);
        chk("R4 model irq", irq, m_flag & local_en & periph_en & global_en);
        chk("R9 model wake", wake, sleep & m_flag & local_en & periph_en);
        chk("R6 model mode", mode, m_mode);
    endtask

    task automatic idle();
        reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
        cyc();
        idle();
    endtask

    task automatic peek(input logic s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle();
        repeat (3) cyc();
        // R6: state while in reset
        peek(1'b0, v); chk("R6 reset ctrl", v, 8'h00);
        peek(1'b1, v); chk("R6 reset flag", v, 8'h00);
        chk("R6 reset mode", mode, 3'd0);
        rst_n = 1'b1;
        cyc();

        // R8: write mode 2
        wr_reg(1'b0, 8'h02);
        chk("R8 mode write", mode, 3'd2);

        // R1: comparator 0 rises; flag after third edge
        cmp_raw = 2'b01;
        cyc(); cyc();
        peek(1'b1, v); chk("R1 flag not yet", v, 8'h00);
        cyc();
        peek(1'b1, v); chk("R1 flag set", v, 8'h01);

        // R3 / R2: clear write loses to a live mismatch
        wr_reg(1'b1, 8'h00);
        peek(1'b1, v); chk("R3 mismatch beats clear", v, 8'h01);

        // R8 / R2: reading ctrl shows outputs and refreshes snapshot
        reg_sel = 1'b0; reg_rd = 1'b1;
        #1; chk("R8 ctrl layout", reg_rdata, 8'h42);
        cyc(); idle();
        wr_reg(1'b1, 8'h00);
        peek(1'b1, v); chk("R3 clear works", v, 8'h00);
        cyc();
        peek(1'b1, v); chk("R2 mismatch ended", v, 8'h00);

        // R3: software set
        wr_reg(1'b1, 8'h01);
        peek(1'b1, v); chk("R3 soft set", v, 8'h01);

        // R4: enable gating
        local_en = 1; periph_en = 1; global_en = 1; #1;
        chk("R4 irq all enabled", irq, 1'b1);
        global_en = 0; #1; chk("R4 irq global off", irq, 1'b0);
        global_en = 1; periph_en = 0; #1; chk("R4 irq periph off", irq, 1'b0);
        periph_en = 1; local_en = 0; #1; chk("R4 irq local off", irq, 1'b0);
        local_en = 1;
        wr_reg(1'b1, 8'h00);
        chk("R4 irq after clear", irq, 1'b0);

        // R4: flag sets with all enables clear
        local_en = 0; periph_en = 0; global_en = 0;
        cmp_raw = 2'b11;
        cyc(); cyc(); cyc();
        peek(1'b1, v); chk("R4 flag sets disabled", v, 8'h01);
        chk("R4 irq stays low", irq, 1'b0);

        // R9: wake without global enable, registers intact
        sleep = 1; local_en = 1; periph_en = 1; #1;
        chk("R9 wake raised", wake, 1'b1);
        chk("R9 irq low without global", irq, 1'b0);
        cyc(); cyc();
        chk("R9 mode kept in sleep", mode, 3'd2);
        sleep = 0; #1;
        chk("R9 wake drops", wake, 1'b0);
        local_en = 0; periph_en = 0;

        // acknowledge: read ctrl then clear
        reg_sel = 0; reg_rd = 1; cyc(); idle();
        wr_reg(1'b1, 8'h00);

        // R5: change reaches compare in the same cycle as a ctrl read
        cmp_raw = 2'b10;
        cyc(); cyc();
        reg_sel = 0; reg_rd = 1;
        #1; chk("R5 read shows new value", reg_rdata, 8'h82);
        cyc(); idle();
        cyc();
        peek(1'b1, v); chk("R5 change lost", v, 8'h00);

        // R1: same kind of change without a read does set
        cmp_raw = 2'b00;
        cyc(); cyc(); cyc();
        peek(1'b1, v); chk("R1 comparator 1 fall sets", v, 8'h01);

        // R7 / R8: mode 111 with bits 7:6 written as 1
        wr_reg(1'b0, 8'hC7);
        cmp_raw = 2'b11;
        repeat (4) cyc();
        peek(1'b0, v); chk("R7 off reads zero", v, 8'h07);
        chk("R8 top bits ignored", mode, 3'd7);

        // R6: mode 000 forces outputs low
        wr_reg(1'b0, 8'h00);
        peek(1'b0, v); chk("R6 hold mode low", v, 8'h00);

        // R6: reset mid-run
        wr_reg(1'b0, 8'h05);
        wr_reg(1'b1, 8'h01);
        rst_n = 0; cyc(); rst_n = 1;
        chk("R6 reset mode", mode, 3'd0);
        peek(1'b1, v); chk("R6 reset flag", v, 8'h00);
        cyc();

        // Pseudo-random phase compared against the model every clock
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            if (r[2:0] == 3'd0) cmp_raw = r[4:3];
            reg_sel   = r[5];
            reg_rd    = (r[9:7] == 3'd0);
            reg_wr    = (r[12:10] == 3'd0);
            reg_wdata = r[20:13];
            local_en  = r[21] | r[22];
            periph_en = r[23] | r[24];
            global_en = r[25];
            sleep     = r[26];
            cyc();
        end
        idle();
        cyc();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule